// File: doc/BRIEF.md
# Real-Time-Clock Host Port and Interrupt Status

This block is the host-facing side of a battery-backed clock chip. The host sees two byte-wide ports. A write to the even port selects one of 128 byte locations. Any access to the odd port then reads or writes the selected location. Most locations are plain storage bytes. Four locations, indices 0x0A to 0x0D, are control and status registers. These are called A, B, C and D below.

Three single-cycle event inputs come from timing logic outside the block: update-ended, alarm match and periodic tick. Each event sets its flag in register C. If the matching enable bit in register B is also set, the summary bit in C goes high and so does the `irq` output. The host clears every flag by reading C. Writing B re-evaluates the interrupt against flags that are already pending. The periodic divider and the calendar counters are not part of this block. The block only exports `per_run`, which tells the external periodic generator whether to run.

The interrupt line is held by a two-state machine. `IRQ_QUIET` is the idle state, with no enabled flag reported. `IRQ_RAISED` means the line is asserted. The machine moves between the two states as follows:
- QUIET to RAISED on the *fresh-enabled-event* transition, when a flag goes from clear to set while its enable is on.
- QUIET to RAISED, or RAISED to RAISED, on the *enable-hits-pending* transition, when a B write turns on an enable whose flag is already set.
- RAISED to QUIET on the *status-read* transition (a read of C).
- RAISED to QUIET on the *enable-miss* transition (a B write that matches no pending flag).
- Either state to QUIET on the *device-reset* transition.

Top module: `cmos_rtc_bus`

## Requirements
- R1: A write to port 0 loads bits [6:0] of the write data into the index; bit 7 is discarded. A read of port 0 returns 0xFF.
- R2: A port 1 write to a storage index (any index except 0x0A to 0x0D) stores the byte there. A later port 1 read at that index returns the same byte.
- R3: Index 0x37 is an alias of the century location 0x32. A write through either index can be read back through the other.
- R4: Writes to C (0x0C) and D (0x0D) have no effect. D always reads 0x80. Bit 7 of A reads 0 whatever is written to it; bits [6:0] of A hold the written value.
- R5: After `rst_n` is released, A=0x26, B=0x02, C=0x00, D=0x80 and `irq`=0.
- R6: Register C layout: bit 7 is the summary bit, bit 6 is the periodic flag, bit 5 is the alarm flag and bit 4 is the update flag. Register B layout: bit 6 enables periodic, bit 5 enables alarm and bit 4 enables update. An event that newly sets a flag whose enable is on sets C bit 7, and `irq` goes to 1 in the next cycle.
- R7: An event whose enable is off still sets its flag, but leaves C bit 7 and `irq` at 0. This holds for the periodic flag as well.
- R8: A read of C returns its current value. From the next cycle, C reads 0x00 and `irq` is 0.
- R9: A write to B whose bits [6:4] overlap a set flag asserts `irq` in the next cycle. A write to B with no overlap drops C bit 7 and `irq`.
- R10: While A[3:0]=0, a periodic event is ignored. `per_run` equals B bit 6 AND (A[3:0] != 0).
- R11: A write to B with bit 7 set stores bit 4 as 0.
- R12: A `dev_reset` pulse clears B bits 6, 5 and 3. It clears every flag in C and drops `irq`. All other bits of B keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_reset | input | 1 | Synchronous device-reset pulse |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_port | input | 1 | 0 = index port, 1 = data port |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the cycle of the access |
| upd_pulse | input | 1 | Update-ended event |
| alm_pulse | input | 1 | Alarm-match event |
| per_pulse | input | 1 | Periodic tick event |
| per_run | output | 1 | Run request for the periodic generator |
| irq | output | 1 | Interrupt request, active high |

## Verification
The interrupt properties assume that each event input is high for a single cycle. Some properties also assume that a read of C or a write to B does not fall in the same cycle as the event they observe; they exclude that case in their preconditions rather than fix a priority. The stimulus drives each access and each event pulse in its own cycle on the falling edge, so every precondition is met cleanly. The bench checks the flag and line effects through reads of C and B and by sampling `irq` after the next rising edge.

// File: rtl/cmos_rtc_pkg.sv
package cmos_rtc_pkg;
    localparam int IDX_W  = 7;
    localparam int DATA_W = 8;

    localparam logic [IDX_W-1:0] IDX_CTRL_A = 7'h0A;
    localparam logic [IDX_W-1:0] IDX_CTRL_B = 7'h0B;
    localparam logic [IDX_W-1:0] IDX_STAT_C = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_STAT_D = 7'h0D;

    localparam logic [DATA_W-1:0] RST_A = 8'h26;
    localparam logic [DATA_W-1:0] RST_B = 8'h02;
    localparam logic [DATA_W-1:0] VAL_D = 8'h80;

    // bit positions in B (enables) and C (flags) line up: 6 periodic, 5 alarm, 4 update
    localparam int EN_LO    = 4;
    localparam int EN_HI    = 6;
    localparam int B_SETBIT = 7;
    localparam int B_UPDEN  = 4;
    localparam int B_PEREN  = 6;
    // device reset drops periodic enable, alarm enable and square-wave enable
    localparam logic [DATA_W-1:0] DEVRST_KEEP = 8'b1001_0111;

    typedef enum logic {IRQ_QUIET, IRQ_RAISED} irq_state_e;
endpackage

// File: rtl/rtc_index_port.sv
module rtc_index_port
    import cmos_rtc_pkg::*;
#(
    parameter logic [IDX_W-1:0] ALIAS_IDX   = 7'h37,
    parameter logic [IDX_W-1:0] CENTURY_IDX = 7'h32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    output logic [IDX_W-1:0] idx_eff,
    output logic             idx_ctrl
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx_q <= '0;
        else if (load) idx_q <= load_val;
    end

    always_comb begin
        idx_eff  = (idx_q == ALIAS_IDX) ? CENTURY_IDX : idx_q;
        idx_ctrl = (idx_eff >= IDX_CTRL_A) && (idx_eff <= IDX_STAT_D);
    end

    assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (idx_q == $past(load_val)));
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/rtc_status_ctrl.sv
module rtc_status_ctrl
    import cmos_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_reset,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              wr_cd,
    input  logic              rd_c,
    input  logic [DATA_W-1:0] wdata,
    input  logic              upd_pulse,
    input  logic              alm_pulse,
    input  logic              per_pulse,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic [DATA_W-1:0] reg_c,
    output logic [DATA_W-1:0] reg_d,
    output logic              per_run,
    output logic              irq
);
    localparam int NFL = EN_HI - EN_LO + 1;

    irq_state_e        state_q, state_n;
    logic [NFL-1:0]    flags_q, flags_n, flags_base, evt, fresh;
    logic [DATA_W-1:0] a_n, b_n, b_wr_val;
    logic              per_ok;

    always_comb begin
        b_wr_val = wdata;
        if (wdata[B_SETBIT]) b_wr_val[B_UPDEN] = 1'b0;
    end

    always_comb begin
        a_n        = reg_a;
        b_n        = reg_b;
        flags_base = rd_c ? '0 : flags_q;
        per_ok     = per_pulse && (reg_a[3:0] != 4'd0);
        evt        = {per_ok, alm_pulse, upd_pulse};
        fresh      = evt & ~flags_base;
        flags_n    = flags_base | evt;
        state_n    = state_q;
        if (wr_a) a_n = {1'b0, wdata[DATA_W-2:0]};
        if (wr_b) b_n = b_wr_val;
        unique case (state_q)
            IRQ_QUIET, IRQ_RAISED: begin
                if (rd_c) state_n = IRQ_QUIET;
                if (wr_b) state_n = ((b_wr_val[EN_HI:EN_LO] & flags_base) != '0)
                                    ? IRQ_RAISED : IRQ_QUIET;
                if ((fresh & b_n[EN_HI:EN_LO]) != '0) state_n = IRQ_RAISED;
            end
            default: state_n = IRQ_QUIET;
        endcase
        if (dev_reset) begin
            b_n     = reg_b & DEVRST_KEEP;
            flags_n = '0;
            state_n = IRQ_QUIET;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
            flags_q <= '0;
            reg_a   <= RST_A;
            reg_b   <= RST_B;
        end else begin
            state_q <= state_n;
            flags_q <= flags_n;
            reg_a   <= a_n;
            reg_b   <= b_n;
        end
    end

    // outputs
    always_comb begin
        irq     = (state_q == IRQ_RAISED);
        reg_c   = {irq, flags_q, {(DATA_W - NFL - 1){1'b0}}};
        reg_d   = VAL_D;
        per_run = reg_b[B_PEREN] && (reg_a[3:0] != 4'd0);
    end

    assert_fresh_event_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && reg_b[B_UPDEN] && !flags_q[0] && !rd_c && !wr_b && !dev_reset) |=> irq);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && !upd_pulse && !alm_pulse && !per_pulse && !dev_reset) |=> (!irq && flags_q == '0));

    assert_irq_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((reg_c[EN_HI:EN_LO] & reg_b[EN_HI:EN_LO]) != '0));

    assert_per_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (per_pulse && reg_a[3:0] == 4'd0 && !flags_q[NFL-1] && !dev_reset) |=> !flags_q[NFL-1]);

    assert_cd_write_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cd && !upd_pulse && !alm_pulse && !per_pulse && !dev_reset) |=> $stable(reg_c));

    assert_dev_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> (!irq && flags_q == '0 && !reg_b[B_PEREN]));
endmodule

// File: rtl/cmos_rtc_bus.sv
module cmos_rtc_bus
    import cmos_rtc_pkg::*;
#(
    parameter logic [IDX_W-1:0] ALIAS_IDX   = 7'h37,
    parameter logic [IDX_W-1:0] CENTURY_IDX = 7'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_reset,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_port,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              upd_pulse,
    input  logic              alm_pulse,
    input  logic              per_pulse,
    output logic              per_run,
    output logic              irq
);
    logic [IDX_W-1:0]  idx;
    logic              idx_ctrl, data_wr, data_rd;
    logic [DATA_W-1:0] store_q, reg_a, reg_b, reg_c, reg_d;

    assign data_wr = acc_en && acc_wr && acc_port;
    assign data_rd = acc_en && !acc_wr && acc_port;

    rtc_index_port #(.ALIAS_IDX(ALIAS_IDX), .CENTURY_IDX(CENTURY_IDX)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_en && acc_wr && !acc_port),
        .load_val (acc_wdata[IDX_W-1:0]),
        .idx_eff  (idx),
        .idx_ctrl (idx_ctrl)
    );

    rtc_byte_store #(.AW(IDX_W), .DW(DATA_W)) u_store (
        .clk   (clk),
        .we    (data_wr && !idx_ctrl),
        .addr  (idx),
        .wdata (acc_wdata),
        .rdata (store_q)
    );

    rtc_status_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_reset (dev_reset),
        .wr_a      (data_wr && idx == IDX_CTRL_A),
        .wr_b      (data_wr && idx == IDX_CTRL_B),
        .wr_cd     (data_wr && (idx == IDX_STAT_C || idx == IDX_STAT_D)),
        .rd_c      (data_rd && idx == IDX_STAT_C),
        .wdata     (acc_wdata),
        .upd_pulse (upd_pulse),
        .alm_pulse (alm_pulse),
        .per_pulse (per_pulse),
        .reg_a     (reg_a),
        .reg_b     (reg_b),
        .reg_c     (reg_c),
        .reg_d     (reg_d),
        .per_run   (per_run),
        .irq       (irq)
    );

    always_comb begin
        if (!acc_port) acc_rdata = 8'hFF;
        else begin
            unique case (idx)
                IDX_CTRL_A: acc_rdata = reg_a;
                IDX_CTRL_B: acc_rdata = reg_b;
                IDX_STAT_C: acc_rdata = reg_c;
                IDX_STAT_D: acc_rdata = reg_d;
                default:    acc_rdata = store_q;
            endcase
        end
    end

    assert_even_read_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !acc_port) |-> (acc_rdata == 8'hFF));
endmodule

// File: tb/cmos_rtc_bus_tb.sv
module cmos_rtc_bus_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_reset = 1'b0;
    logic       acc_en = 1'b0, acc_wr = 1'b0, acc_port = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       upd_pulse = 1'b0, alm_pulse = 1'b0, per_pulse = 1'b0;
    logic       per_run, irq;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    cmos_rtc_bus u_dut (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_port(acc_port),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .upd_pulse(upd_pulse), .alm_pulse(alm_pulse), .per_pulse(per_pulse),
        .per_run(per_run), .irq(irq)
    );

    // entry: [21:18] requirement, [17] read, [16] port, [15:8] write data, [7:0] expected
    function automatic logic [21:0] V(input logic [3:0] rq, input logic rd,
                                      input logic pt, input logic [7:0] d, input logic [7:0] e);
        return {rq, rd, pt, d, e};
    endfunction

    localparam int NV = 27;
    localparam logic [21:0] VEC [NV] = '{
        // R2 storage round trip
        V(2,0,0,8'h20,0), V(2,0,1,8'h5A,0), V(2,0,0,8'h21,0), V(2,0,1,8'hC3,0),
        V(2,0,0,8'h20,0), V(2,1,1,0,8'h5A), V(2,0,0,8'h21,0), V(2,1,1,0,8'hC3),
        // R1 index bit 7 discarded, even-port read
        V(1,0,0,8'hA0,0), V(1,1,1,0,8'h5A), V(1,1,0,0,8'hFF),
        // R3 alias 0x37 <-> 0x32
        V(3,0,0,8'h37,0), V(3,0,1,8'h19,0), V(3,0,0,8'h32,0), V(3,1,1,0,8'h19),
        V(3,0,1,8'h20,0), V(3,0,0,8'h37,0), V(3,1,1,0,8'h20),
        // R4 D and C read-only, A bit 7 read-only
        V(4,0,0,8'h0D,0), V(4,0,1,8'h00,0), V(4,1,1,0,8'h80),
        V(4,0,0,8'h0A,0), V(4,0,1,8'hA5,0), V(4,1,1,0,8'h25),
        V(4,0,0,8'h0C,0), V(4,0,1,8'hF0,0), V(4,1,1,0,8'h00)
    };

    task automatic check(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic pt, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_port = pt; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic pt, output logic [7:0] q);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_port = pt;
        #1 q = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] ix, output logic [7:0] q);
        wr(1'b0, ix);
        rd(1'b1, q);
    endtask

    task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
        wr(1'b0, ix);
        wr(1'b1, d);
    endtask

    // kind: 0 update, 1 alarm, 2 periodic, 3 device reset
    task automatic pulse(input int kind);
        @(negedge clk);
        case (kind)
            0: upd_pulse = 1'b1;
            1: alm_pulse = 1'b1;
            2: per_pulse = 1'b1;
            default: dev_reset = 1'b1;
        endcase
        @(negedge clk);
        upd_pulse = 1'b0; alm_pulse = 1'b0; per_pulse = 1'b0; dev_reset = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5 reset values
        check("R5", "irq after reset", {7'd0, irq}, 8'h00);
        rd_reg(8'h0A, q); check("R5", "A", q, 8'h26);
        rd_reg(8'h0B, q); check("R5", "B", q, 8'h02);
        rd_reg(8'h0C, q); check("R5", "C", q, 8'h00);
        rd_reg(8'h0D, q); check("R5", "D", q, 8'h80);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] e = VEC[i];
            string rq = $sformatf("R%0d", e[21:18]);
            if (e[17]) begin
                rd(e[16], q);
                check(rq, $sformatf("vector %0d", i), q, e[7:0]);
            end else wr(e[16], e[15:8]);
        end

        // R7 update event with enable off
        pulse(0);
        check("R7", "irq with UIE off", {7'd0, irq}, 8'h00);
        rd_reg(8'h0C, q); check("R7", "C after update", q, 8'h10);
        // R8 read cleared C
        rd(1'b1, q); check("R8", "C after read", q, 8'h00);

        // R6 enabled update event
        wr_reg(8'h0B, 8'h12);
        pulse(0);
        check("R6", "irq after enabled update", {7'd0, irq}, 8'h01);
        rd_reg(8'h0C, q); check("R6", "C summary+UF", q, 8'h90);
        check("R8", "irq after C read", {7'd0, irq}, 8'h00);

        // R9 enable hits pending flag / enable miss
        wr_reg(8'h0B, 8'h02);
        pulse(1);
        check("R7", "irq alarm AIE off", {7'd0, irq}, 8'h00);
        wr_reg(8'h0B, 8'h22);
        check("R9", "irq on enable hit", {7'd0, irq}, 8'h01);
        wr_reg(8'h0B, 8'h02);
        check("R9", "irq on enable miss", {7'd0, irq}, 8'h00);
        rd_reg(8'h0C, q); check("R9", "C after miss", q, 8'h20);

        // R10 periodic gating by rate select
        wr_reg(8'h0A, 8'h20);
        wr_reg(8'h0B, 8'h42);
        check("R10", "per_run rate 0", {7'd0, per_run}, 8'h00);
        pulse(2);
        rd_reg(8'h0C, q); check("R10", "C after ignored tick", q, 8'h00);
        wr_reg(8'h0A, 8'h26);
        check("R10", "per_run rate 6", {7'd0, per_run}, 8'h01);
        pulse(2);
        check("R6", "irq periodic", {7'd0, irq}, 8'h01);
        rd_reg(8'h0C, q); check("R6", "C summary+PF", q, 8'hC0);

        // R7 periodic flag with PIE off
        wr_reg(8'h0B, 8'h02);
        pulse(2);
        check("R7", "irq periodic PIE off", {7'd0, irq}, 8'h00);
        rd_reg(8'h0C, q); check("R7", "C PF only", q, 8'h40);

        // R11 set bit forces update enable off
        wr_reg(8'h0B, 8'h92);
        rd(1'b1, q); check("R11", "B with set bit", q, 8'h82);

        // R12 device reset
        wr_reg(8'h0B, 8'h7A);
        pulse(0);
        check("R12", "irq before device reset", {7'd0, irq}, 8'h01);
        pulse(3);
        check("R12", "irq after device reset", {7'd0, irq}, 8'h00);
        rd_reg(8'h0B, q); check("R12", "B after device reset", q, 8'h12);
        rd_reg(8'h0C, q); check("R12", "C after device reset", q, 8'h00);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule